// File: doc/BRIEF.md
# Buffered Serializing Pin Port with Strobe and Timed Transfers

The block is a clocked pin port that sits between a narrow pin bus and a 32-bit internal word interface. On the way out it accepts one word through a valid/ready handshake and sends it to the pins as a series of narrow slices, one per port clock cycle, starting with the least significant slice. On the way in it collects narrow pin samples, least significant slice first, into one word and offers it to the internal side with a valid flag.

The pins are sampled on the rising edge of the port clock, and the output bus changes on the falling edge. This lets a downstream device capture the output on its own rising edge with a full half period of margin. The port clock is either the internal reference clock or an external clock pin, chosen by a select input.

Each direction has its own timing options:
- An input strobe restricts sampling to cycles where a companion valid pin is high.
- An output strobe drives a valid pin on every cycle that carries fresh data.
- A 16-bit free-running cycle counter can hold back the first sample or the first launch of a word until it reaches a programmed value.
- A selectable 0 to 5 cycle delay on the input pins compensates for board skew.

Top module: `bufport`

## Requirements
- R1: While reset is held, the output bus holds the configured initial value (0xAA by default), the output strobe and `rx_valid` are low, `tx_ready` is high and `port_count` reads 0.
- R2: A word accepted on `tx_*` appears on `pin_out` as WORD_W/PIN_W consecutive slices, bits [8k+7:8k] in the k-th cycle after acceptance (k from 0). Each slice changes at the falling edge of its cycle, so the bus still shows the old value right after the rising edge.
- R3: Pin samples are placed into the word least significant slice first. The completed word is offered on `rx_word` with `rx_valid` high on the cycle after its last sample edge, and stays offered until `rx_ready` is seen high at a rising edge.
- R4: With input strobing enabled, a rising edge takes a sample only if `pin_in_vld` is high. Other data is ignored. With strobing disabled, every rising edge takes a sample.
- R5: With output strobing enabled, `pin_out_vld` is high exactly in the cycles that launch a slice. With it disabled, `pin_out_vld` stays low.
- R6: `tx_ready` is low while a word still has slices other than the last to send. It is high in the cycle of the last slice, and a word offered then is launched in the next cycle with no gap.
- R7: When no new word follows the last slice, `pin_out` keeps the last slice and `pin_out_vld` drops low.
- R8: With output timing enabled, the first slice of the next accepted word is launched in the cycle where `port_count` equals `cfg_out_ts`. Until then the bus holds its old value. The remaining slices follow in consecutive cycles.
- R9: With input timing enabled, the first sample of a word is taken at the rising edge that ends the cycle in which `port_count` equals `cfg_in_ts`. Later samples of that word follow the normal rule. After the word completes, capture waits for the next match.
- R10: `cfg_in_dly` delays pin data and pin strobe by that many port clock cycles. Values above 5 act as 5.
- R11: `port_count` advances by one on every rising edge of the selected port clock and wraps modulo 2^16. `clk_sel` high selects `ext_clk`, and low selects `ref_clk`.
- R12: If a new word completes while the previous one is still unread, the newer word replaces it in `rx_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Internal reference clock |
| ext_clk | input | 1 | External clock pin |
| clk_sel | input | 1 | 1 selects ext_clk as port clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_in_strobe | input | 1 | Enable input strobe qualification |
| cfg_out_strobe | input | 1 | Enable output valid strobe |
| cfg_in_dly | input | 3 | Input delay in cycles (0..5, larger clamps) |
| cfg_in_ts_en | input | 1 | Enable timed capture |
| cfg_in_ts | input | 16 | Count at which capture starts |
| cfg_out_ts_en | input | 1 | Enable timed launch |
| cfg_out_ts | input | 16 | Count at which launch starts |
| port_count | output | 16 | Free-running port clock count |
| tx_word | input | 32 | Word to send |
| tx_valid | input | 1 | tx_word is valid |
| tx_ready | output | 1 | Port accepts a word |
| rx_word | output | 32 | Received word |
| rx_valid | output | 1 | rx_word is valid |
| rx_ready | input | 1 | Consumer takes rx_word |
| pin_in | input | 8 | Input pin bus |
| pin_in_vld | input | 1 | Input data-valid pin |
| pin_out | output | 8 | Output pin bus |
| pin_out_vld | output | 1 | Output data-valid pin |

## Verification
The properties assume the configuration inputs change only while both directions are idle, and never between a falling edge and the rising edge that follows it. They also assume `clk_sel` changes only while reset is held, because a switch at any other time could produce a clipped port clock pulse. The stimulus respects both conditions. All inputs change two time units after a rising edge of the reference clock, configuration changes only between transfers, and the clock source is switched inside a reset window. A word is offered on `tx_*` only while `tx_ready` is already high.

// File: rtl/bufport_pkg.sv
package bufport_pkg;

  // Output serializer phases
  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,  // nothing to send
    TX_WAIT  = 2'd1,  // word held, waiting for count match
    TX_SHIFT = 2'd2   // slices going out
  } tx_state_e;

  // Effective delay: requests beyond the line length use the full line
  function automatic int clamp_delay(input int req, input int lim);
    return (req > lim) ? lim : req;
  endfunction

endpackage

// File: rtl/bufport_tick_cnt.sv
module bufport_tick_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + CNT_W'(1);
  end

endmodule

// File: rtl/bufport_in_skew.sv
module bufport_in_skew #(
  parameter int W       = 8,
  parameter int MAX_DLY = 5,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     din,
  input  logic             din_vld,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     dout,
  output logic             dout_vld
);
  import bufport_pkg::*;

  // stage[k] holds the pins as seen k+1 edges ago
  logic [W:0] stage [MAX_DLY];
  logic [W:0] tap;
  int         eff;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < MAX_DLY; k++) stage[k] <= '0;
    end else begin
      stage[0] <= {din_vld, din};
      for (int k = 1; k < MAX_DLY; k++) stage[k] <= stage[k-1];
    end
  end

  always_comb begin
    eff = clamp_delay(int'(sel), MAX_DLY);
    tap = {din_vld, din};
    for (int k = 1; k <= MAX_DLY; k++) begin
      if (eff == k) tap = stage[k-1];
    end
  end

  assign dout     = tap[W-1:0];
  assign dout_vld = tap[W];

endmodule

// File: rtl/bufport_gather.sv
module bufport_gather #(
  parameter int PIN_W  = 8,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  d,
  input  logic              d_vld,
  input  logic              strobe_en,
  input  logic              ts_en,
  input  logic [CNT_W-1:0]  ts_cnt,
  input  logic [CNT_W-1:0]  count,
  output logic [WORD_W-1:0] word,
  output logic              word_vld,
  input  logic              word_rdy
);

  localparam int SLICES = WORD_W / PIN_W;
  localparam int IDX_W  = (SLICES > 1) ? $clog2(SLICES) : 1;

  logic [WORD_W-1:0] acc, acc_nx;
  logic [IDX_W-1:0]  idx;
  logic              started;
  logic              qual, take, last;

  assign qual = strobe_en ? d_vld : 1'b1;
  assign take = qual && (!ts_en || started || (count == ts_cnt));
  assign last = (idx == IDX_W'(SLICES - 1));

  always_comb begin
    acc_nx = acc;
    acc_nx[idx*PIN_W +: PIN_W] = d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      idx      <= '0;
      started  <= 1'b0;
      word     <= '0;
      word_vld <= 1'b0;
    end else begin
      if (word_vld && word_rdy) word_vld <= 1'b0;
      if (take) begin
        acc <= acc_nx;
        if (last) begin
          idx      <= '0;
          started  <= 1'b0;
          word     <= acc_nx;   // newest word wins over an unread one
          word_vld <= 1'b1;
        end else begin
          idx     <= idx + IDX_W'(1);
          started <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/bufport_scatter.sv
module bufport_scatter #(
  parameter int             PIN_W    = 8,
  parameter int             WORD_W   = 32,
  parameter int             CNT_W    = 16,
  parameter logic [PIN_W-1:0] INIT_OUT = 8'hAA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              strobe_en,
  input  logic              ts_en,
  input  logic [CNT_W-1:0]  ts_cnt,
  input  logic [CNT_W-1:0]  count,
  output logic              launch,
  output logic [PIN_W-1:0]  pin_d,
  output logic              pin_vld
);
  import bufport_pkg::*;

  localparam int SLICES = WORD_W / PIN_W;
  localparam int IDX_W  = (SLICES > 1) ? $clog2(SLICES) : 1;

  tx_state_e         st;
  logic [WORD_W-1:0] hold;
  logic [IDX_W-1:0]  idx;
  logic              last, accept;
  logic [PIN_W-1:0]  slice;

  assign launch   = (st == TX_SHIFT) || ((st == TX_WAIT) && (count == ts_cnt));
  assign last     = (idx == IDX_W'(SLICES - 1));
  assign wr_ready = (st == TX_IDLE) || (launch && last);
  assign accept   = wr_valid && wr_ready;
  assign slice    = hold[idx*PIN_W +: PIN_W];

  // Rising-edge side: word buffer and slice pointer
  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= TX_IDLE;
      hold <= '0;
      idx  <= '0;
    end else begin
      if (launch) idx <= last ? '0 : idx + IDX_W'(1);
      if (accept) begin
        hold <= wr_word;
        idx  <= '0;
        st   <= ts_en ? TX_WAIT : TX_SHIFT;
      end else if (launch) begin
        st <= last ? TX_IDLE : TX_SHIFT;
      end
    end
  end

  // Falling-edge side: pin launch register
  always_ff @(negedge clk) begin
    if (rst) begin
      pin_d   <= INIT_OUT;
      pin_vld <= 1'b0;
    end else begin
      pin_vld <= launch && strobe_en;
      if (launch) pin_d <= slice;
    end
  end

endmodule

// File: rtl/bufport.sv
module bufport #(
  parameter int               PIN_W    = 8,
  parameter int               WORD_W   = 32,
  parameter int               CNT_W    = 16,
  parameter int               MAX_DLY  = 5,
  parameter logic [PIN_W-1:0] INIT_OUT = 8'hAA
) (
  input  logic                         ref_clk,
  input  logic                         ext_clk,
  input  logic                         clk_sel,
  input  logic                         rst,
  input  logic                         cfg_in_strobe,
  input  logic                         cfg_out_strobe,
  input  logic [$clog2(MAX_DLY+1)-1:0] cfg_in_dly,
  input  logic                         cfg_in_ts_en,
  input  logic [CNT_W-1:0]             cfg_in_ts,
  input  logic                         cfg_out_ts_en,
  input  logic [CNT_W-1:0]             cfg_out_ts,
  output logic [CNT_W-1:0]             port_count,
  input  logic [WORD_W-1:0]            tx_word,
  input  logic                         tx_valid,
  output logic                         tx_ready,
  output logic [WORD_W-1:0]            rx_word,
  output logic                         rx_valid,
  input  logic                         rx_ready,
  input  logic [PIN_W-1:0]             pin_in,
  input  logic                         pin_in_vld,
  output logic [PIN_W-1:0]             pin_out,
  output logic                         pin_out_vld
);

  localparam int SEL_W = $clog2(MAX_DLY + 1);

  logic             pclk;
  logic [PIN_W-1:0] skew_d;
  logic             skew_vld;
  logic             tx_launch;

  assign pclk = clk_sel ? ext_clk : ref_clk;

  bufport_tick_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (pclk),
    .rst   (rst),
    .count (port_count)
  );

  bufport_in_skew #(.W(PIN_W), .MAX_DLY(MAX_DLY), .SEL_W(SEL_W)) u_skew (
    .clk      (pclk),
    .rst      (rst),
    .din      (pin_in),
    .din_vld  (pin_in_vld),
    .sel      (cfg_in_dly),
    .dout     (skew_d),
    .dout_vld (skew_vld)
  );

  bufport_gather #(.PIN_W(PIN_W), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk       (pclk),
    .rst       (rst),
    .d         (skew_d),
    .d_vld     (skew_vld),
    .strobe_en (cfg_in_strobe),
    .ts_en     (cfg_in_ts_en),
    .ts_cnt    (cfg_in_ts),
    .count     (port_count),
    .word      (rx_word),
    .word_vld  (rx_valid),
    .word_rdy  (rx_ready)
  );

  bufport_scatter #(.PIN_W(PIN_W), .WORD_W(WORD_W), .CNT_W(CNT_W),
                    .INIT_OUT(INIT_OUT)) u_tx (
    .clk       (pclk),
    .rst       (rst),
    .wr_word   (tx_word),
    .wr_valid  (tx_valid),
    .wr_ready  (tx_ready),
    .strobe_en (cfg_out_strobe),
    .ts_en     (cfg_out_ts_en),
    .ts_cnt    (cfg_out_ts),
    .count     (port_count),
    .launch    (tx_launch),
    .pin_d     (pin_out),
    .pin_vld   (pin_out_vld)
  );

endmodule

// File: rtl/bufport_chk.sv
module bufport_chk #(
  parameter int PIN_W  = 8,
  parameter int WORD_W = 32
) (
  input logic             pclk,
  input logic             rst,
  input logic             cfg_out_strobe,
  input logic             launch,
  input logic [PIN_W-1:0] pin_out,
  input logic             pin_out_vld,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             rx_valid,
  input logic             rx_ready
);

  // R5: strobe pin mirrors the serializer's launch decision
  p_strobe_tracks_launch_r5: assert property (@(posedge pclk) disable iff (rst)
    cfg_out_strobe |-> (pin_out_vld == launch));

  // R7: bus keeps its value over any cycle without a launch
  p_dout_hold_r7: assert property (@(posedge pclk) disable iff (rst)
    !launch |-> $stable(pin_out));

  // R3: an unread word stays offered
  p_in_hold_r3: assert property (@(posedge pclk) disable iff (rst)
    (rx_valid && !rx_ready) |=> rx_valid);

  // R6: after acceptance the port is busy for at least one cycle
  if (WORD_W / PIN_W > 1) begin : g_multi
    p_no_accept_next_r6: assert property (@(posedge pclk) disable iff (rst)
      (tx_valid && tx_ready) |=> !tx_ready);
  end

endmodule

bind bufport bufport_chk #(.PIN_W(PIN_W), .WORD_W(WORD_W)) u_chk (
  .pclk           (pclk),
  .rst            (rst),
  .cfg_out_strobe (cfg_out_strobe),
  .launch         (tx_launch),
  .pin_out        (pin_out),
  .pin_out_vld    (pin_out_vld),
  .tx_valid       (tx_valid),
  .tx_ready       (tx_ready),
  .rx_valid       (rx_valid),
  .rx_ready       (rx_ready)
);

// File: tb/sim_bufport.sv
module sim_bufport;
  localparam int CLK_PERIOD = 10;
  localparam int PIN_W   = 8;
  localparam int WORD_W  = 32;
  localparam int CNT_W   = 16;
  localparam int MAX_DLY = 5;
  localparam int SEL_W   = $clog2(MAX_DLY + 1);
  localparam int SLICES  = WORD_W / PIN_W;

  // stimulus table for the output path; expected slices derive from R2
  localparam logic [31:0] TX_VEC [6] = '{32'h0403_0201, 32'hDEAD_BEEF,
                                         32'h0000_0000, 32'hFFFF_FFFF,
                                         32'h5A5A_A5A5, 32'h8001_7FFE};
  localparam int DLY_REQ [4] = '{0, 2, 5, 7};
  localparam int DLY_LAT [4] = '{1, 3, 6, 6};

  logic ref_clk = 1'b0, ext_clk = 1'b0;
  logic clk_sel = 1'b0, rst = 1'b1;
  logic cfg_in_strobe = 1'b1, cfg_out_strobe = 1'b1;
  logic [SEL_W-1:0] cfg_in_dly = '0;
  logic cfg_in_ts_en = 1'b0, cfg_out_ts_en = 1'b0;
  logic [CNT_W-1:0] cfg_in_ts = '0, cfg_out_ts = '0;
  logic [CNT_W-1:0] port_count;
  logic [WORD_W-1:0] tx_word = '0;
  logic tx_valid = 1'b0;
  logic tx_ready;
  logic [WORD_W-1:0] rx_word;
  logic rx_valid;
  logic rx_ready = 1'b1;
  logic [PIN_W-1:0] pin_in = '0;
  logic pin_in_vld = 1'b0;
  logic [PIN_W-1:0] pin_out;
  logic pin_out_vld;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;
  always #(3*CLK_PERIOD/2) ext_clk = ~ext_clk;

  bufport u0 (
    .ref_clk(ref_clk), .ext_clk(ext_clk), .clk_sel(clk_sel), .rst(rst),
    .cfg_in_strobe(cfg_in_strobe), .cfg_out_strobe(cfg_out_strobe),
    .cfg_in_dly(cfg_in_dly), .cfg_in_ts_en(cfg_in_ts_en), .cfg_in_ts(cfg_in_ts),
    .cfg_out_ts_en(cfg_out_ts_en), .cfg_out_ts(cfg_out_ts),
    .port_count(port_count),
    .tx_word(tx_word), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .pin_in(pin_in), .pin_in_vld(pin_in_vld),
    .pin_out(pin_out), .pin_out_vld(pin_out_vld)
  );

  // Move to two time units after the next rising edge
  task automatic tick();
    @(posedge ref_clk);
    #2;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Offer a word while tx_ready is known high; returns after the accepting edge
  task automatic push(input logic [31:0] w);
    tx_word  = w;
    tx_valid = 1'b1;
    tick();
    tx_valid = 1'b0;
  endtask

  // Drive one word as four strobed slices, least significant first
  task automatic feed(input logic [31:0] w);
    for (int k = 0; k < SLICES; k++) begin
      pin_in     = w[k*PIN_W +: PIN_W];
      pin_in_vld = 1'b1;
      tick();
    end
    pin_in_vld = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] w, last_out, got_word;
    logic [CNT_W-1:0] c0, tgt;
    int lat;
    bit got;

    // ---- R1: reset state
    repeat (4) tick();
    check("R1 pin_out", 32'(pin_out), 32'hAA);
    check("R1 pin_out_vld", 32'(pin_out_vld), 0);
    check("R1 rx_valid", 32'(rx_valid), 0);
    check("R1 tx_ready", 32'(tx_ready), 1);
    check("R1 port_count", 32'(port_count), 0);
    rst = 1'b0;
    tick();

    // ---- R2/R5/R6/R7: table of words through the output path
    last_out = 32'hAA;
    for (int v = 0; v < 6; v++) begin
      w = TX_VEC[v];
      push(w);
      check("R2 falling-edge launch", 32'(pin_out), last_out);
      for (int k = 0; k < SLICES; k++) begin
        #5;
        check("R2 slice", 32'(pin_out), 32'(w[k*PIN_W +: PIN_W]));
        check("R5 strobe high", 32'(pin_out_vld), 1);
        if (k == 1) check("R6 ready low mid-word", 32'(tx_ready), 0);
        if (k == SLICES-1) check("R6 ready on last slice", 32'(tx_ready), 1);
        tick();
      end
      #5;
      last_out = 32'(w[WORD_W-1 -: PIN_W]);
      check("R7 hold last slice", 32'(pin_out), last_out);
      check("R7 strobe low", 32'(pin_out_vld), 0);
      tick();
    end

    // ---- R5: output strobe disabled
    cfg_out_strobe = 1'b0;
    w = 32'h1357_9BDF;
    push(w);
    for (int k = 0; k < SLICES; k++) begin
      #5;
      check("R5 data without strobe", 32'(pin_out), 32'(w[k*PIN_W +: PIN_W]));
      check("R5 strobe stays low", 32'(pin_out_vld), 0);
      tick();
    end
    cfg_out_strobe = 1'b1;
    tick();

    // ---- R6: back-to-back words without a gap
    tx_word = 32'hA4A3_A2A1;
    tx_valid = 1'b1;
    tick();
    tx_word = 32'hB4B3_B2B1;
    for (int k = 0; k < SLICES; k++) begin
      #5;
      check("R6 first word", 32'(pin_out), 32'(8'hA1 + 8'(k)));
      tick();
    end
    tx_valid = 1'b0;
    for (int k = 0; k < SLICES; k++) begin
      #5;
      check("R6 gapless second word", 32'(pin_out), 32'(8'hB1 + 8'(k)));
      check("R6 strobe continuous", 32'(pin_out_vld), 1);
      tick();
    end
    last_out = 32'hB4;
    tick();

    // ---- R8: timed launch
    cfg_out_ts_en = 1'b1;
    tgt = port_count + CNT_W'(6);
    cfg_out_ts = tgt;
    w = 32'hC4C3_C2C1;
    push(w);
    for (int n = 0; n < 20; n++) begin
      c0 = port_count;
      #5;
      if (c0 == tgt) begin
        check("R8 first slice at match", 32'(pin_out), 32'hC1);
        break;
      end
      check("R8 hold before match", 32'(pin_out), last_out);
      tick();
    end
    for (int k = 1; k < SLICES; k++) begin
      tick();
      #5;
      check("R8 following slices", 32'(pin_out), 32'(w[k*PIN_W +: PIN_W]));
    end
    cfg_out_ts_en = 1'b0;
    tick();

    // ---- R3/R4: strobed capture with gaps of ignored data
    pin_in = 8'h44; pin_in_vld = 1'b1; tick();
    pin_in = 8'hEE; pin_in_vld = 1'b0; tick();
    pin_in = 8'h33; pin_in_vld = 1'b1; tick();
    pin_in = 8'h22; pin_in_vld = 1'b1; tick();
    pin_in = 8'hFF; pin_in_vld = 1'b0; tick();
    check("R4 no word before fourth valid", 32'(rx_valid), 0);
    pin_in = 8'h11; pin_in_vld = 1'b1; tick();
    pin_in_vld = 1'b0;
    check("R3 word offered", 32'(rx_valid), 1);
    check("R4 strobed word", rx_word, 32'h1122_3344);
    tick();
    check("R3 word taken", 32'(rx_valid), 0);

    // ---- R9/R4: timed capture, no strobe
    pin_in = 8'h5A;
    tgt = port_count + CNT_W'(5);
    cfg_in_ts = tgt;
    cfg_in_strobe = 1'b0;
    cfg_in_ts_en = 1'b1;
    for (int n = 0; n < 20 && port_count != tgt; n++) begin
      check("R9 nothing before match", 32'(rx_valid), 0);
      tick();
    end
    for (int k = 0; k < SLICES; k++) begin
      pin_in = 8'hA1 + 8'(k * 17);
      tick();
    end
    pin_in = 8'h5A;
    check("R9 timed word", rx_word, 32'hD4C3_B2A1);
    check("R9 timed word valid", 32'(rx_valid), 1);
    for (int n = 0; n < 6; n++) begin
      tick();
      check("R9 one-shot capture", 32'(rx_valid), 0);
    end
    cfg_in_strobe = 1'b1;
    cfg_in_ts_en = 1'b0;
    tick();

    // ---- R12: unread word replaced by newer one
    rx_ready = 1'b0;
    feed(32'h0102_0304);
    check("R3 first word unread", rx_word, 32'h0102_0304);
    tick();
    check("R3 held while not ready", 32'(rx_valid), 1);
    feed(32'h0A0B_0C0D);
    check("R12 newer word wins", rx_word, 32'h0A0B_0C0D);
    rx_ready = 1'b1;
    tick();
    check("R12 cleared after read", 32'(rx_valid), 0);

    // ---- R10: input delay settings
    for (int i = 0; i < 4; i++) begin
      cfg_in_dly = SEL_W'(DLY_REQ[i]);
      repeat (2) tick();
      for (int k = 0; k < SLICES - 1; k++) begin
        pin_in = 8'hD8 - 8'(k * 17);
        pin_in_vld = 1'b1;
        tick();
      end
      pin_in = 8'hA5;
      got = 1'b0;
      lat = 0;
      got_word = '0;
      for (int n = 1; n <= 10; n++) begin
        tick();
        if (n == 1) pin_in_vld = 1'b0;
        if (rx_valid && !got) begin
          got = 1'b1;
          lat = n;
          got_word = rx_word;
        end
      end
      check("R10 delay latency", lat, DLY_LAT[i]);
      check("R10 delayed word", got_word, 32'hA5B6_C7D8);
    end
    cfg_in_dly = '0;

    // ---- R11: counter steps on the reference clock
    c0 = port_count;
    repeat (7) tick();
    check("R11 count step ref", 32'(port_count - c0), 7);

    // ---- R11: external clock selected under reset
    rst = 1'b1;
    repeat (10) tick();
    clk_sel = 1'b1;
    repeat (10) tick();
    rst = 1'b0;
    repeat (3) tick();
    c0 = port_count;
    repeat (30) tick();
    lat = int'(port_count - c0);
    check("R11 ext clock rate", 32'((lat >= 9) && (lat <= 11)), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule